// File: doc/BRIEF.md
# Half-Cycle Bus Cycle Sequencer

This block runs one asynchronous bus transaction at a time for an internal requester. It paces each transaction in half-cycles, with one clock of the block equal to one bus half-cycle. A normal transfer has two parts. First comes an address part, with the address strobe raised. Then comes a data part, in which the upper and/or lower data strobes are raised and the data bus is either sampled or driven. If the acknowledge input is low when the address part ends, the block adds two-half-cycle wait pairs until the acknowledge is seen. A bus-error input that is sampled at the same points ends the cycle early.

The requester presents a byte address, a direction, a byte/word size, three function-code bits, write data and a cycle kind. The four kinds are:

- a normal transfer;
- an interrupt acknowledge, which is a read on function code 7;
- a reset cycle, which raises the reset output and no strobes;
- an address hold, which raises the address strobe alone for a fixed span.

On byte writes the block copies the byte onto both data lanes. On byte reads it returns the unselected lane as all ones. A word access at an odd address is refused without any bus activity. The requester holds its request until the block gives a one-clock completion pulse.

Top module: `busseq_top`

## Requirements
- R1: After reset, busAs, busUds, busLds, busReset, busDataOe and doneOut are 0 and busRw is 1 (read).
- R2: With acknowledge present in time, a transfer holds busAs high for exactly 8 clocks after the accepting edge. The data strobes are high in clocks 5 to 8 only. doneOut is high in clock 9.
- R3: Acknowledge is sampled in the 4th address clock and then in the last clock of each wait pair. Each sample without acknowledge adds 2 clocks of busAs with no data strobes before the 4-clock data part.
- R4: While busAs is high, busAddr equals request address bits [23:1].
- R5: A byte access raises only busUds when address bit 0 is 0 and only busLds when it is 1. A word access raises both.
- R6: A write drives busDataOe only during the data part, and busRw is 0 while busAs is high. busDataOut carries the word for word writes and the low request byte on both lanes for byte writes.
- R7: Read data is returned as sampled on the last data clock. For a byte read the unselected lane is 8'hFF: an even address gives {hi, FF} and an odd address gives {FF, lo}.
- R8: busFc follows the request code for normal transfers. For kind 1 (interrupt acknowledge) busFc is 3'b111 and the cycle is a read.
- R9: A bus error at a sample point, which takes priority over acknowledge, ends the cycle without a data part. doneOut comes one clock later with rspBusErr set.
- R10: Kind 2 (reset cycle) holds busReset high for RESET_HC clocks with busAs low. doneOut follows in the next clock.
- R11: Kind 3 (address hold) holds busAs high for HOLD_HC clocks with no data strobes, ignoring acknowledge. doneOut follows in the next clock.
- R12: A word request (kind 0 or 1) with address bit 0 set raises no strobe. doneOut comes in clock 1 with rspAddrErr set.
- R13: doneOut lasts one clock, and a request still held during the done clock is not started again in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present, held until doneOut |
| reqKind | input | 2 | 0 transfer, 1 interrupt ack, 2 reset cycle, 3 address hold |
| reqRead | input | 1 | 1 read, 0 write |
| reqWord | input | 1 | 1 word, 0 byte |
| reqFc | input | 3 | Function code for normal transfers |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 16 | Write data (byte writes use bits 7:0) |
| doneOut | output | 1 | One-clock completion pulse |
| rspData | output | 16 | Read result, lane-filled |
| rspBusErr | output | 1 | Cycle ended by bus error |
| rspAddrErr | output | 1 | Request refused: odd word address |
| busAddr | output | 23 | Word address |
| busAs | output | 1 | Address strobe |
| busUds | output | 1 | Upper data strobe |
| busLds | output | 1 | Lower data strobe |
| busRw | output | 1 | 1 read, 0 write |
| busFc | output | 3 | Function code |
| busReset | output | 1 | Reset output |
| busDataOut | output | 16 | Write data onto the bus |
| busDataOe | output | 1 | Write data enable |
| busDataIn | input | 16 | Read data from the bus |
| busDtack | input | 1 | Transfer acknowledge |
| busBerr | input | 1 | Bus error |

## Verification
Every output comes from a register, so a request driven before an edge is counted from that edge. The address part covers clocks 1 to 4 and each wait pair adds 2 clocks. The data strobes follow for 4 clocks, and doneOut with its response appears in the clock after the last strobe clock. The bench drives and samples on the falling edge and indexes each sample by its clock number after acceptance. The acknowledge model raises busDtack once a set number of address-strobe clocks has elapsed. Every count and index is compared with the figure worked out from R2, R3 and R9 to R12.

// File: rtl/busseq_pkg.sv
package busseq_pkg;
  typedef enum logic [1:0] {
    KIND_XFER  = 2'd0,
    KIND_IACK  = 2'd1,
    KIND_RESET = 2'd2,
    KIND_HOLD  = 2'd3
  } cycleKind_e;

  typedef struct packed {
    logic load;
    logic capture;
    logic asOn;
    logic dsOn;
    logic rstOn;
  } ctrlStrobe_t;
endpackage

// File: rtl/busseq_ctrl.sv
module busseq_ctrl
  import busseq_pkg::*;
#(
  parameter int ADDR_HC  = 4,
  parameter int DATA_HC  = 4,
  parameter int WAIT_HC  = 2,
  parameter int RESET_HC = 16,
  parameter int HOLD_HC  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  logic        reqWord,
  input  logic        reqAddr0,
  input  logic        busDtack,
  input  logic        busBerr,
  output ctrlStrobe_t strobe,
  output logic        doneOut,
  output logic        rspBusErr,
  output logic        rspAddrErr
);
  localparam int MAX_A  = (ADDR_HC > DATA_HC) ? ADDR_HC : DATA_HC;
  localparam int MAX_B  = (RESET_HC > HOLD_HC) ? RESET_HC : HOLD_HC;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_HC = (MAX_C > WAIT_HC) ? MAX_C : WAIT_HC;
  localparam int CNT_W  = $clog2(MAX_HC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WAIT, S_DATA, S_RST, S_HOLD} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept = (state == S_IDLE) && reqValid && !doneOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cnt        <= '0;
      doneOut    <= 1'b0;
      rspBusErr  <= 1'b0;
      rspAddrErr <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      cnt     <= cnt + 1'b1;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (accept) begin
            rspBusErr  <= 1'b0;
            rspAddrErr <= 1'b0;
            if (reqKind == KIND_RESET) state <= S_RST;
            else if (reqKind == KIND_HOLD) state <= S_HOLD;
            else if (reqWord && reqAddr0) begin
              doneOut    <= 1'b1;
              rspAddrErr <= 1'b1;
            end else state <= S_ADDR;
          end
        end
        S_ADDR, S_WAIT: begin
          if (cnt == CNT_W'((state == S_ADDR) ? ADDR_HC - 1 : WAIT_HC - 1)) begin
            cnt <= '0;
            if (busBerr) begin
              state     <= S_IDLE;
              doneOut   <= 1'b1;
              rspBusErr <= 1'b1;
            end else if (busDtack) state <= S_DATA;
            else state <= S_WAIT;
          end
        end
        S_DATA: if (cnt == CNT_W'(DATA_HC - 1)) begin
          state   <= S_IDLE;
          doneOut <= 1'b1;
        end
        S_RST: if (cnt == CNT_W'(RESET_HC - 1)) begin
          state   <= S_IDLE;
          doneOut <= 1'b1;
        end
        S_HOLD: if (cnt == CNT_W'(HOLD_HC - 1)) begin
          state   <= S_IDLE;
          doneOut <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load    = accept;
    strobe.capture = (state == S_DATA) && (cnt == CNT_W'(DATA_HC - 1));
    strobe.asOn    = (state == S_ADDR) || (state == S_WAIT) ||
                     (state == S_DATA) || (state == S_HOLD);
    strobe.dsOn    = (state == S_DATA);
    strobe.rstOn   = (state == S_RST);
  end

  // R13: completion is a single-clock pulse
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    doneOut |=> !doneOut);
  // R2: the address strobe only drops when the cycle completes
  assert_as_ends_done_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe.asOn) |-> doneOut);
  // R12: a refused request never touched the bus
  assert_addr_err_no_as_R12: assert property (@(posedge clk) disable iff (rst)
    (doneOut && rspAddrErr) |-> !$past(strobe.asOn));
endmodule

// File: rtl/busseq_datapath.sv
module busseq_datapath
  import busseq_pkg::*;
#(
  parameter int ADDR_IN_W  = 32,
  parameter int BUS_ADDR_W = 23,
  parameter int DATA_W     = 16,
  parameter int FC_W       = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobe_t           strobe,
  input  logic [1:0]            reqKind,
  input  logic                  reqRead,
  input  logic                  reqWord,
  input  logic [FC_W-1:0]       reqFc,
  input  logic [ADDR_IN_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W-1:0]     busDataIn,
  output logic [DATA_W-1:0]     rspData,
  output logic [BUS_ADDR_W-1:0] busAddr,
  output logic                  busAs,
  output logic                  busUds,
  output logic                  busLds,
  output logic                  busRw,
  output logic [FC_W-1:0]       busFc,
  output logic                  busReset,
  output logic [DATA_W-1:0]     busDataOut,
  output logic                  busDataOe
);
  localparam int LANE_W = DATA_W / 2;

  logic [BUS_ADDR_W-1:0] addrQ;
  logic                  lowByteQ;
  logic                  readQ;
  logic                  wordQ;
  logic [FC_W-1:0]       fcQ;
  logic [DATA_W-1:0]     wdataQ;
  logic [DATA_W-1:0]     readFilled;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ    <= '0;
      lowByteQ <= 1'b0;
      readQ    <= 1'b1;
      wordQ    <= 1'b0;
      fcQ      <= '0;
      wdataQ   <= '0;
      rspData  <= '0;
    end else begin
      if (strobe.load) begin
        addrQ    <= reqAddr[BUS_ADDR_W:1];
        lowByteQ <= reqAddr[0];
        readQ    <= reqRead || (reqKind == KIND_IACK);
        wordQ    <= reqWord;
        fcQ      <= (reqKind == KIND_IACK) ? {FC_W{1'b1}} : reqFc;
        wdataQ   <= reqWdata;
      end
      if (strobe.capture && readQ) rspData <= readFilled;
    end
  end

  // lane 0 is the low lane (selected by odd addresses), lane 1 the high lane
  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic laneSel;
    assign laneSel = wordQ || (lowByteQ == (lane == 0));
    assign readFilled[lane*LANE_W +: LANE_W] =
      laneSel ? busDataIn[lane*LANE_W +: LANE_W] : {LANE_W{1'b1}};
    assign busDataOut[lane*LANE_W +: LANE_W] =
      wordQ ? wdataQ[lane*LANE_W +: LANE_W] : wdataQ[LANE_W-1:0];
  end

  assign busAddr   = addrQ;
  assign busFc     = fcQ;
  assign busAs     = strobe.asOn;
  assign busUds    = strobe.dsOn && (wordQ || !lowByteQ);
  assign busLds    = strobe.dsOn && (wordQ || lowByteQ);
  assign busRw     = strobe.asOn ? readQ : 1'b1;
  assign busReset  = strobe.rstOn;
  assign busDataOe = strobe.dsOn && !readQ;

  // R5: a byte access never raises both lanes
  assert_byte_one_lane_R5: assert property (@(posedge clk) disable iff (rst)
    (busUds && busLds) |-> wordQ);
  // R6: write data only driven in a write cycle with the address strobe up
  assert_oe_in_write_R6: assert property (@(posedge clk) disable iff (rst)
    busDataOe |-> (busAs && !busRw));
endmodule

// File: rtl/busseq_top.sv
module busseq_top
  import busseq_pkg::*;
#(
  parameter int ADDR_IN_W  = 32,
  parameter int BUS_ADDR_W = 23,
  parameter int DATA_W     = 16,
  parameter int FC_W       = 3,
  parameter int ADDR_HC    = 4,
  parameter int DATA_HC    = 4,
  parameter int WAIT_HC    = 2,
  parameter int RESET_HC   = 16,
  parameter int HOLD_HC    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  input  logic [1:0]            reqKind,
  input  logic                  reqRead,
  input  logic                  reqWord,
  input  logic [FC_W-1:0]       reqFc,
  input  logic [ADDR_IN_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  output logic                  doneOut,
  output logic [DATA_W-1:0]     rspData,
  output logic                  rspBusErr,
  output logic                  rspAddrErr,
  output logic [BUS_ADDR_W-1:0] busAddr,
  output logic                  busAs,
  output logic                  busUds,
  output logic                  busLds,
  output logic                  busRw,
  output logic [FC_W-1:0]       busFc,
  output logic                  busReset,
  output logic [DATA_W-1:0]     busDataOut,
  output logic                  busDataOe,
  input  logic [DATA_W-1:0]     busDataIn,
  input  logic                  busDtack,
  input  logic                  busBerr
);
  ctrlStrobe_t strobe;

  busseq_ctrl #(
    .ADDR_HC(ADDR_HC), .DATA_HC(DATA_HC), .WAIT_HC(WAIT_HC),
    .RESET_HC(RESET_HC), .HOLD_HC(HOLD_HC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind),
    .reqWord(reqWord), .reqAddr0(reqAddr[0]), .busDtack(busDtack),
    .busBerr(busBerr), .strobe(strobe), .doneOut(doneOut),
    .rspBusErr(rspBusErr), .rspAddrErr(rspAddrErr)
  );

  busseq_datapath #(
    .ADDR_IN_W(ADDR_IN_W), .BUS_ADDR_W(BUS_ADDR_W),
    .DATA_W(DATA_W), .FC_W(FC_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .reqKind(reqKind),
    .reqRead(reqRead), .reqWord(reqWord), .reqFc(reqFc),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busDataIn(busDataIn),
    .rspData(rspData), .busAddr(busAddr), .busAs(busAs),
    .busUds(busUds), .busLds(busLds), .busRw(busRw), .busFc(busFc),
    .busReset(busReset), .busDataOut(busDataOut), .busDataOe(busDataOe)
  );

  // R2: data strobes only inside an address-strobed cycle
  assert_ds_in_as_R2: assert property (@(posedge clk) disable iff (rst)
    (busUds || busLds) |-> busAs);
  // R10: reset output and address strobe never overlap
  assert_reset_alone_R10: assert property (@(posedge clk) disable iff (rst)
    busReset |-> !(busAs || busDataOe));
endmodule

// File: tb/tb_busseq_top.sv
module tb_busseq_top;
  localparam int RESET_HC = 16;
  localparam int HOLD_HC  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic        reqRead = 1'b1;
  logic        reqWord = 1'b1;
  logic [2:0]  reqFc = 3'd0;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        doneOut, rspBusErr, rspAddrErr;
  logic [15:0] rspData;
  logic [22:0] busAddr;
  logic        busAs, busUds, busLds, busRw, busReset, busDataOe;
  logic [2:0]  busFc;
  logic [15:0] busDataOut;
  logic [15:0] busDataIn = '0;
  logic        busDtack = 1'b0;
  logic        busBerr = 1'b0;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  busseq_top #(.RESET_HC(RESET_HC), .HOLD_HC(HOLD_HC)) dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind),
    .reqRead(reqRead), .reqWord(reqWord), .reqFc(reqFc), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .doneOut(doneOut), .rspData(rspData),
    .rspBusErr(rspBusErr), .rspAddrErr(rspAddrErr), .busAddr(busAddr),
    .busAs(busAs), .busUds(busUds), .busLds(busLds), .busRw(busRw),
    .busFc(busFc), .busReset(busReset), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busDataIn(busDataIn), .busDtack(busDtack),
    .busBerr(busBerr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one request; dly = address-strobe clocks before dtack (or berr) rises.
  task automatic runCycle(input string req, input logic [1:0] kind, input bit rd,
                          input bit word, input logic [31:0] addr, input logic [2:0] fc,
                          input logic [15:0] wd, input logic [15:0] busPat,
                          input int dly, input bit useBerr, input bit holdAfter);
    int asN = 0, udsN = 0, ldsN = 0, rstN = 0, oeN = 0, firstDs = 0, doneIdx = 0;
    int addrBad = 0, fcBad = 0, rwBad = 0, outBad = 0;
    int w, expAs, expDs, expDone, expUds, expLds, expOe;
    bit expRead, oddWord, gotBerr = 0, gotAerr = 0;
    logic [15:0] gotRsp = '0, expRsp, expOut;
    logic [2:0] expFc;
    expRead = rd || (kind == 2'd1);
    expFc   = (kind == 2'd1) ? 3'b111 : fc;
    oddWord = word && addr[0] && (kind < 2'd2);
    w       = (dly > 4) ? (dly - 3) / 2 : 0;
    expOut  = word ? wd : {wd[7:0], wd[7:0]};
    expRsp  = word ? busPat : (addr[0] ? {8'hFF, busPat[7:0]} : {busPat[15:8], 8'hFF});
    @(negedge clk);
    reqKind = kind; reqRead = rd; reqWord = word; reqAddr = addr; reqFc = fc;
    reqWdata = wd; busDataIn = busPat; reqValid = 1'b1;
    for (int k = 1; k <= 80 && doneIdx == 0; k++) begin
      @(negedge clk);
      if (busAs) begin
        asN++;
        if (busAddr != addr[23:1]) addrBad++;
        if (busFc != expFc) fcBad++;
        if (busRw != expRead) rwBad++;
      end
      if (busUds) udsN++;
      if (busLds) ldsN++;
      if ((busUds || busLds) && firstDs == 0) firstDs = k;
      if (busReset) rstN++;
      if (busDataOe) begin
        oeN++;
        if (busDataOut != expOut) outBad++;
      end
      busDtack = !useBerr && busAs && (asN >= dly);
      busBerr  = useBerr && busAs && (asN >= dly);
      if (doneOut) begin
        doneIdx = k; gotRsp = rspData; gotBerr = rspBusErr; gotAerr = rspAddrErr;
      end
    end
    busDtack = 1'b0; busBerr = 1'b0;
    if (holdAfter) begin
      @(negedge clk);
      chk(!doneOut && !busAs, "R13", "done/strobe after done with request held",
          {doneOut, busAs}, 0);
    end
    reqValid = 1'b0;
    if (kind == 2'd2) begin
      expAs = 0; expDs = 0; expDone = RESET_HC + 1;
    end else if (kind == 2'd3) begin
      expAs = HOLD_HC; expDs = 0; expDone = HOLD_HC + 1;
    end else if (oddWord) begin
      expAs = 0; expDs = 0; expDone = 1;
    end else if (useBerr) begin
      expAs = 4 + 2 * w; expDs = 0; expDone = 5 + 2 * w;
    end else begin
      expAs = 8 + 2 * w; expDs = 4; expDone = 9 + 2 * w;
    end
    expUds = (expDs != 0 && (word || !addr[0])) ? 4 : 0;
    expLds = (expDs != 0 && (word || addr[0])) ? 4 : 0;
    expOe  = (expDs != 0 && !expRead) ? 4 : 0;
    chk(asN == expAs, req, "address strobe clocks", asN, expAs);
    chk(doneIdx == expDone, req, "done clock index", doneIdx, expDone);
    chk(udsN == expUds, req, "upper strobe clocks", udsN, expUds);
    chk(ldsN == expLds, req, "lower strobe clocks", ldsN, expLds);
    if (expDs != 0)
      chk(firstDs == 5 + 2 * w, req, "first data strobe clock", firstDs, 5 + 2 * w);
    chk(addrBad == 0, req, "word address mismatches", addrBad, 0);
    chk(fcBad == 0, req, "function code mismatches", fcBad, 0);
    chk(rwBad == 0, req, "direction mismatches", rwBad, 0);
    chk(oeN == expOe, req, "write enable clocks", oeN, expOe);
    chk(outBad == 0, req, "write data mismatches", outBad, 0);
    chk(rstN == ((kind == 2'd2) ? RESET_HC : 0), req, "reset output clocks", rstN,
        (kind == 2'd2) ? RESET_HC : 0);
    chk(gotBerr == useBerr, req, "bus error flag", gotBerr, useBerr);
    chk(gotAerr == oddWord, req, "address error flag", gotAerr, oddWord);
    if (expRead && expDs != 0)
      chk(gotRsp == expRsp, req, "read data", gotRsp, expRsp);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!busAs && !busUds && !busLds && !busReset && !busDataOe && !doneOut && busRw,
        "R1", "outputs in reset",
        {busAs, busUds, busLds, busReset, busDataOe, doneOut, busRw}, 1);
  endtask

  task automatic testWordRead();   // R2 R4 R8 R7
    runCycle("R2", 2'd0, 1, 1, 32'hFF12_3456, 3'b101, 16'h0, 16'hBEEF, 4, 0, 0);
    runCycle("R4", 2'd0, 1, 1, 32'h00AB_CDE0, 3'b010, 16'h0, 16'h1234, 1, 0, 0);
  endtask

  task automatic testWaits();      // R3
    runCycle("R3", 2'd0, 1, 1, 32'h0000_1000, 3'b001, 16'h0, 16'h5A5A, 5, 0, 0);
    runCycle("R3", 2'd0, 1, 1, 32'h0000_2002, 3'b001, 16'h0, 16'hA5A5, 6, 0, 0);
    runCycle("R3", 2'd0, 0, 1, 32'h0000_3004, 3'b001, 16'hC3C3, 16'h0, 9, 0, 0);
  endtask

  task automatic testByteReads();  // R5 R7
    runCycle("R7", 2'd0, 1, 0, 32'h0000_4000, 3'b001, 16'h0, 16'h9A3C, 4, 0, 0);
    runCycle("R5", 2'd0, 1, 0, 32'h0000_4001, 3'b001, 16'h0, 16'h9A3C, 4, 0, 0);
  endtask

  task automatic testWrites();     // R6 R5
    runCycle("R6", 2'd0, 0, 0, 32'h0000_5000, 3'b001, 16'h77E4, 16'h0, 4, 0, 0);
    runCycle("R6", 2'd0, 0, 0, 32'h0000_5001, 3'b001, 16'h11D2, 16'h0, 4, 0, 0);
    runCycle("R6", 2'd0, 0, 1, 32'h0000_5002, 3'b001, 16'hCAFE, 16'h0, 4, 0, 0);
  endtask

  task automatic testIack();       // R8
    runCycle("R8", 2'd1, 0, 0, 32'h0000_000B, 3'b000, 16'h0, 16'h0042, 4, 0, 0);
  endtask

  task automatic testBerr();       // R9
    runCycle("R9", 2'd0, 1, 1, 32'h0000_6000, 3'b001, 16'h0, 16'h0, 4, 1, 0);
    runCycle("R9", 2'd0, 0, 1, 32'h0000_6002, 3'b001, 16'h1111, 16'h0, 6, 1, 0);
  endtask

  task automatic testResetKind();  // R10
    runCycle("R10", 2'd2, 1, 1, 32'h0, 3'b000, 16'h0, 16'h0, 99, 0, 0);
  endtask

  task automatic testHold();       // R11
    runCycle("R11", 2'd3, 1, 1, 32'h0000_7000, 3'b110, 16'h0, 16'h0, 1, 0, 0);
  endtask

  task automatic testAddrErr();    // R12
    runCycle("R12", 2'd0, 1, 1, 32'h0000_8001, 3'b001, 16'h0, 16'h0, 4, 0, 0);
  endtask

  task automatic testHandshake();  // R13
    runCycle("R13", 2'd0, 1, 1, 32'h0000_9000, 3'b001, 16'h0, 16'h2468, 4, 0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk) rst = 1'b0;
    testWordRead();
    testWaits();
    testByteReads();
    testWrites();
    testIack();
    testBerr();
    testResetKind();
    testHold();
    testAddrErr();
    testHandshake();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule